// File: doc/BRIEF.md
# Interleaved I/Q Word Splitter

This block takes one shared data bus on which in-phase (I) and quadrature (Q) samples arrive alternately and turns it into a pair of channel words that move together. A steering line marks each word as I or Q. A write strobe captures the word on its rising edge. A pairing machine accepts an I word followed by a Q word as one complete pair. A separate load strobe then presents both words to the downstream filter pair in the same cycle. The write and load strobes may be driven from the same net.

All logic runs on one fast system clock. Both strobes and the reset/sleep control are sampled on that clock. A strobe "rising edge" is a sample of 1 that follows a sample of 0. The reset/sleep control is active high, and its effect depends on how long it is held. A short hold clears the block. A long hold puts the block to sleep with its outputs frozen.

Top module: `iq_deinterleaver`

## Requirements
- R1: After `rst_n` is released, `i_word`, `q_word` and `pair_stb` are 0 and `asleep` is 0.
- R2: A write rising edge captures `data_in` as an I word when `sel_i` is 1, and as a Q word when `sel_i` is 0. Bit 9 is the MSB.
- R3: A pair is formed only when a Q word is captured while an I word is pending. A load rising edge with a formed pair copies both words to `i_word` and `q_word`. These outputs are visible, together with a one-cycle `pair_stb`, one clock after that edge is sampled.
- R4: A second I word before the Q word replaces the pending I word. A Q word with no pending I word is dropped and forms no pair. A load edge with no formed pair changes nothing.
- R5: `i_word` and `q_word` change only in a cycle where `pair_stb` is 1, or right after a short reset.
- R6: With write and load tied together, the I then Q sequence is released on the next shared edge after the Q capture. That same edge captures the next word.
- R7: If `rst_sleep` is held for 1 to HOLD-1 consecutive samples and then returns low, the clock that samples it low clears both outputs and the pending state to zero. The pairing machine returns to waiting for I.
- R8: Holding `rst_sleep` for HOLD (default 4) consecutive samples raises `asleep` after the HOLD-th sample. While `rst_sleep` is high or `asleep` is 1, the block ignores both strobes and the outputs hold.
- R9: When `rst_sleep` returns low after sleep, `asleep` drops on that clock. Any pending I word and any unreleased pair are discarded. `i_word` and `q_word` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 10 | Shared interleaved sample bus |
| sel_i | input | 1 | 1 steers the word to I, 0 to Q |
| wr_strb | input | 1 | Write strobe, captured on rising edge |
| ld_strb | input | 1 | Load strobe, releases a pair on rising edge |
| rst_sleep | input | 1 | Active-high reset (short hold) or sleep (long hold) |
| i_word | output | 10 | Released I word |
| q_word | output | 10 | Released Q word |
| pair_stb | output | 1 | One-cycle pulse when a pair is released |
| asleep | output | 1 | Sleep status |

## Verification
A captured word has no effect on the ports until a load edge. The released words and `pair_stb` appear one clock after the load edge is sampled. The short-reset clear appears one clock after `rst_sleep` is sampled low. `asleep` rises one clock after the HOLD-th high sample. The bench changes inputs only on falling edges, and it compares the ports on the next falling edge against a cycle model that it steps on each rising edge. It also checks fixed expected values at the exact cycle each directed result is due, including the cycle before a tied-strobe release, where nothing may yet have moved.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

  typedef enum logic {
    WANT_I = 1'b0,
    WANT_Q = 1'b1
  } pair_ph_e;

  // a strobe edge is a high sample after a low sample
  function automatic logic rising(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  // a control hold that ended before reaching the sleep threshold
  function automatic logic short_hold(input int unsigned cnt, input int unsigned hold);
    return (cnt != 0) && (cnt < hold);
  endfunction

endpackage

// File: rtl/iqd_edge.sv
module iqd_edge
  import iqd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = rising(lvl, prev);
endmodule

// File: rtl/iqd_hold_disc.sv
module iqd_hold_disc
  import iqd_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl,
  output logic asleep,
  output logic rst_evt,
  output logic wake_evt
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      asleep <= 1'b0;
    end else if (ctl) begin
      if (cnt != HOLD_C) cnt <= cnt + 1'b1;
      if (cnt >= HOLD_C - 1'b1) asleep <= 1'b1;
    end else begin
      cnt    <= '0;
      asleep <= 1'b0;
    end
  end

  assign rst_evt  = !ctl && short_hold(int'(cnt), HOLD);
  assign wake_evt = !ctl && asleep;
endmodule

// File: rtl/iqd_pairer.sv
module iqd_pairer
  import iqd_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          sel,
  input  logic [DW-1:0] din,
  input  logic          rel,
  input  logic          clr_all,
  input  logic          clr_pair,
  output logic [DW-1:0] i_out,
  output logic [DW-1:0] q_out,
  output logic          upd,
  output logic          rdy
);
  pair_ph_e      ph;
  logic [DW-1:0] i_pend;
  logic [DW-1:0] pair_i;
  logic [DW-1:0] pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= WANT_I;
      i_pend <= '0;
      pair_i <= '0;
      pair_q <= '0;
      rdy    <= 1'b0;
      i_out  <= '0;
      q_out  <= '0;
      upd    <= 1'b0;
    end else if (clr_all) begin
      ph     <= WANT_I;
      i_pend <= '0;
      pair_i <= '0;
      pair_q <= '0;
      rdy    <= 1'b0;
      i_out  <= '0;
      q_out  <= '0;
      upd    <= 1'b0;
    end else if (clr_pair) begin
      ph  <= WANT_I;
      rdy <= 1'b0;
      upd <= 1'b0;
    end else begin
      upd <= rel && rdy;
      if (rel && rdy) begin
        i_out <= pair_i;
        q_out <= pair_q;
        rdy   <= 1'b0;
      end
      if (cap) begin
        if (sel) begin
          i_pend <= din;
          ph     <= WANT_Q;
        end else if (ph == WANT_Q) begin
          pair_i <= i_pend;
          pair_q <= din;
          rdy    <= 1'b1;
          ph     <= WANT_I;
        end
      end
    end
  end
endmodule

// File: rtl/iq_deinterleaver.sv
module iq_deinterleaver #(
  parameter int DW   = 10,
  parameter int HOLD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_in,
  input  logic          sel_i,
  input  logic          wr_strb,
  input  logic          ld_strb,
  input  logic          rst_sleep,
  output logic [DW-1:0] i_word,
  output logic [DW-1:0] q_word,
  output logic          pair_stb,
  output logic          asleep
);
  logic wr_rise, ld_rise;
  logic rst_evt, wake_evt;
  logic busy, cap_ok, rel_ok;
  logic pair_rdy;

  iqd_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .lvl(wr_strb), .rise(wr_rise));
  iqd_edge u_ld_edge (.clk(clk), .rst_n(rst_n), .lvl(ld_strb), .rise(ld_rise));

  iqd_hold_disc #(.HOLD(HOLD)) u_disc (
    .clk(clk), .rst_n(rst_n), .ctl(rst_sleep),
    .asleep(asleep), .rst_evt(rst_evt), .wake_evt(wake_evt)
  );

  assign busy   = rst_sleep | asleep;
  assign cap_ok = wr_rise & ~busy;
  assign rel_ok = ld_rise & ~busy;

  iqd_pairer #(.DW(DW)) u_pair (
    .clk(clk), .rst_n(rst_n), .cap(cap_ok), .sel(sel_i), .din(data_in),
    .rel(rel_ok), .clr_all(rst_evt), .clr_pair(wake_evt),
    .i_out(i_word), .q_out(q_word), .upd(pair_stb), .rdy(pair_rdy)
  );
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_sleep,
  input logic [DW-1:0] i_word,
  input logic [DW-1:0] q_word,
  input logic          pair_stb,
  input logic          asleep,
  input logic          pair_rdy,
  input logic          rst_evt
);
  AST_RELEASE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> $past(pair_rdy)); // R3

  AST_OUT_MOVES_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(i_word) && $stable(q_word)) |-> (pair_stb || $past(rst_evt))); // R5

  AST_SHORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (i_word == '0 && q_word == '0 && !asleep)); // R7

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> ($stable(i_word) && $stable(q_word) && !pair_stb)); // R8

  AST_SLEEP_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(rst_sleep)); // R8

  AST_WAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !rst_sleep) |=> !asleep); // R9
endmodule

bind iq_deinterleaver iqd_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sleep(rst_sleep), .i_word(i_word),
  .q_word(q_word), .pair_stb(pair_stb), .asleep(asleep),
  .pair_rdy(pair_rdy), .rst_evt(rst_evt)
);

// File: tb/iq_deinterleaver_bench.sv
module iq_deinterleaver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] data_in = '0;
  logic       sel_i = 1'b0, wr_strb = 1'b0, ld_strb = 1'b0, rst_sleep = 1'b0;
  logic [9:0] i_word, q_word;
  logic       pair_stb, asleep;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  iq_deinterleaver u_iq_deinterleaver (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .sel_i(sel_i),
    .wr_strb(wr_strb), .ld_strb(ld_strb), .rst_sleep(rst_sleep),
    .i_word(i_word), .q_word(q_word), .pair_stb(pair_stb), .asleep(asleep)
  );

  // bench-side model of the requirements
  bit m_wp, m_lp, m_sleep, m_wantq, m_rdy, m_upd;
  int m_cnt;
  int m_ip, m_pi, m_pq, m_io, m_qo;

  function automatic bit edge_of(bit now_v, bit was_v);
    return now_v && !was_v;
  endfunction

  always @(posedge clk) begin
    bit wr_e, ld_e, busy, short_e, wake_e;
    if (!rst_n) begin
      m_wp = 0; m_lp = 0; m_sleep = 0; m_wantq = 0; m_rdy = 0; m_upd = 0;
      m_cnt = 0; m_ip = 0; m_pi = 0; m_pq = 0; m_io = 0; m_qo = 0;
    end else begin
      wr_e = edge_of(wr_strb, m_wp);
      ld_e = edge_of(ld_strb, m_lp);
      busy = rst_sleep || m_sleep;
      short_e = !rst_sleep && m_cnt > 0 && m_cnt < 4;
      wake_e  = !rst_sleep && m_sleep;
      m_upd = 0;
      if (short_e) begin
        m_wantq = 0; m_rdy = 0; m_ip = 0; m_pi = 0; m_pq = 0; m_io = 0; m_qo = 0;
      end else if (wake_e) begin
        m_wantq = 0; m_rdy = 0;
      end else if (!busy) begin
        if (ld_e && m_rdy) begin
          m_io = m_pi; m_qo = m_pq; m_upd = 1; m_rdy = 0;
        end
        if (wr_e) begin
          if (sel_i) begin
            m_ip = data_in; m_wantq = 1;
          end else if (m_wantq) begin
            m_pi = m_ip; m_pq = data_in; m_rdy = 1; m_wantq = 0;
          end
        end
      end
      if (rst_sleep) begin
        if (m_cnt < 4) m_cnt = m_cnt + 1;
        m_sleep = (m_cnt >= 4);
      end else begin
        m_cnt = 0; m_sleep = 0;
      end
      m_wp = wr_strb; m_lp = ld_strb;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag, "i_word(model)", int'(i_word), m_io);
      chk(tag, "q_word(model)", int'(q_word), m_qo);
      chk(tag, "pair_stb(model)", int'(pair_stb), int'(m_upd));
      chk(tag, "asleep(model)", int'(asleep), int'(m_sleep));
    end
  end

  task automatic cyc(input bit w, input bit l, input bit s, input bit c, input logic [9:0] d);
    wr_strb = w; ld_strb = l; sel_i = s; rst_sleep = c; data_in = d;
    @(negedge clk);
  endtask

  task automatic wr_word(input bit s, input logic [9:0] d);
    cyc(0, 0, s, 0, d);
    cyc(1, 0, s, 0, d);
  endtask

  task automatic ld_pulse();
    cyc(0, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, '0);
  endtask

  task automatic ctl_hold(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 1, '0);
    cyc(0, 0, 0, 0, '0);
  endtask

  initial begin
    int unsigned seed_val;
    int burst;
    bit tied;
    seed_val = $urandom(32'd20240611);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "i_word", int'(i_word), 0);
    chk("R1", "q_word", int'(q_word), 0);
    chk("R1", "asleep", int'(asleep), 0);

    // R2 / R3 basic pair
    tag = "R2";
    wr_word(1, 10'h155);
    wr_word(0, 10'h2AA);
    chk("R3", "no release before load", int'(i_word), 0);
    tag = "R3";
    ld_pulse();
    chk("R3", "pair_stb", int'(pair_stb), 1);
    chk("R2", "i_word", int'(i_word), 'h155);
    chk("R2", "q_word", int'(q_word), 'h2AA);
    cyc(0, 0, 0, 0, '0);
    chk("R3", "pair_stb one cycle", int'(pair_stb), 0);

    // R4 repeated I overwrites, lone Q dropped
    tag = "R4";
    wr_word(1, 10'h011);
    wr_word(1, 10'h022);
    wr_word(0, 10'h033);
    ld_pulse();
    chk("R4", "i_word overwrite", int'(i_word), 'h022);
    chk("R4", "q_word", int'(q_word), 'h033);
    wr_word(0, 10'h3FF);
    ld_pulse();
    chk("R4", "lone Q no stb", int'(pair_stb), 0);
    chk("R4", "lone Q i hold", int'(i_word), 'h022);
    chk("R4", "lone Q q hold", int'(q_word), 'h033);

    // R7 short reset
    tag = "R7";
    ctl_hold(3);
    chk("R7", "i_word cleared", int'(i_word), 0);
    chk("R7", "q_word cleared", int'(q_word), 0);
    chk("R7", "asleep", int'(asleep), 0);

    // R6 tied strobes
    tag = "R6";
    cyc(0, 0, 1, 0, 10'h101);
    cyc(1, 1, 1, 0, 10'h101);
    cyc(0, 0, 0, 0, 10'h202);
    cyc(1, 1, 0, 0, 10'h202);
    chk("R6", "no release on Q edge", int'(i_word), 0);
    cyc(0, 0, 1, 0, 10'h303);
    cyc(1, 1, 1, 0, 10'h303);
    chk("R6", "pair_stb", int'(pair_stb), 1);
    chk("R6", "i_word", int'(i_word), 'h101);
    chk("R6", "q_word", int'(q_word), 'h202);
    cyc(0, 0, 0, 0, '0);

    // R8 sleep holds, R9 wake discards
    tag = "R8";
    wr_word(1, 10'h0AB);
    wr_word(0, 10'h0CD);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, '0);
    chk("R8", "asleep", int'(asleep), 1);
    cyc(0, 1, 0, 1, '0);
    cyc(0, 0, 0, 1, '0);
    chk("R8", "i_word held", int'(i_word), 'h101);
    chk("R8", "pair_stb", int'(pair_stb), 0);
    tag = "R9";
    cyc(0, 0, 0, 0, '0);
    chk("R9", "asleep dropped", int'(asleep), 0);
    chk("R9", "i_word kept", int'(i_word), 'h101);
    ld_pulse();
    chk("R9", "pair discarded", int'(pair_stb), 0);
    chk("R9", "q_word kept", int'(q_word), 'h202);

    // random phase, model compared every cycle
    tag = "R3";
    burst = 0;
    tied = 0;
    for (int n = 0; n < 4000; n++) begin
      bit w, l, c;
      if (n == 2000) tied = 1;
      w = 1'($urandom % 2);
      l = tied ? w : 1'($urandom % 2);
      if (burst > 0) begin
        c = 1; burst--;
      end else begin
        c = 0;
        if ($urandom % 60 == 0) burst = 1 + int'($urandom % 6);
      end
      cyc(w, l, 1'($urandom % 2), c, 10'($urandom % 1024));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired during %s actual=running expected=done", tag);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule